// File: doc/BRIEF.md
# Bus-Mapped GPIO and Interrupt Expander

This block is a pin expander that sits on a host memory bus. It holds a bank of output registers that drive output pins, and a bank of input registers that return the sampled levels of input pins. It also has one interrupt-pending register that collects rising-edge events from up to 16 source pins. The pending state reaches the host as a single summary interrupt line.

The host reads the pending register to learn which sources fired. It clears them by writing a fixed clear code to that same register. A build parameter chooses whether the clear code is all ones or all zeros. There is no per-source mask, so every pending bit drives the summary line. The register width (8 or 16 bits) and the bus width (16 or 32 bits) are parameters. A pin's position inside its bank decides which register holds it and which bit within that register.

Top module: `gpio_irq_expander`

## Requirements
- R1: Register index r sits at byte address r << S, where S is 1 for a 16-bit bus and 2 for a 32-bit bus. Address bits below S are ignored. Output registers use indexes 0..N_OUT_REGS-1. Input registers follow them. The pending register comes after the input registers. Reads of any other index return zero, and writes to any other index change nothing.
- R2: Output pin p is driven by bit (p mod REG_W) of output register p / REG_W. Input pin p is read at bit (p mod REG_W) of register N_OUT_REGS + p / REG_W.
- R3: A write to an output register stores the low REG_W bits of the write data. That value drives the pins and reads back unchanged until the next write to that same register.
- R4: A read of an input register returns the pin levels after a two-flop synchronizer. Writes to input registers have no effect.
- R5: A read of the pending register returns one pending bit per source in bits N_IRQ-1..0. All higher bits read as zero.
- R6: A pending bit sets on a rising edge of its synchronized source. A source held high does not set its bit again. A set bit stays set until it is cleared.
- R7: With INV_ACK=0, a write of 0xFFFF in data bits 15..0 to the pending register clears all pending bits. With INV_ACK=1, the clear code is 0x0000. Any other value written there has no effect.
- R8: A source edge that lands in the same cycle as a clearing write leaves its pending bit set.
- R9: irq_out is a registered OR of all pending bits, with no masking. It is low in the cycle after a clearing write. If bits are still pending, it rises again in the following cycle.
- R10: Reset clears the output registers, the pending bits and irq_out to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Byte address |
| wr_en | input | 1 | Write strobe for the current cycle |
| wdata | input | BUS_W | Write data |
| rdata | output | BUS_W | Read data for addr (combinational) |
| out_pins | output | N_OUT_REGS*REG_W | Output pins |
| in_pins | input | N_IN_REGS*REG_W | Input pins (asynchronous) |
| irq_src | input | N_IRQ | Interrupt source pins (asynchronous) |
| irq_out | output | 1 | Summary interrupt, rising edge means new work |

## Verification
Every output register is swept through all 256 values while its neighbour is watched, which separates a wrong register or bit slice from a correct one. Every input register is swept the same way, and a stray write to it confirms that input registers cannot be written. Sources are raised one at a time, then several at once, then held high, which separates edge detection from level detection and shows how the bits accumulate. Clearing writes are tried with a wrong code, with the correct code, and with a fresh edge landing in the same cycle as the clear; these cover the clear-code decode, the edge-wins rule and the drop-then-rise of the summary line.

// File: rtl/gpio_irq_expander.sv
module gpio_irq_expander #(
  parameter int BUS_W      = 16,
  parameter int REG_W      = 8,
  parameter int N_OUT_REGS = 2,
  parameter int N_IN_REGS  = 2,
  parameter int N_IRQ      = 8,
  parameter bit INV_ACK    = 1'b0,
  parameter int ADDR_W     = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          wr_en,
  input  logic [BUS_W-1:0]              wdata,
  output logic [BUS_W-1:0]              rdata,
  output logic [N_OUT_REGS*REG_W-1:0]   out_pins,
  input  logic [N_IN_REGS*REG_W-1:0]    in_pins,
  input  logic [N_IRQ-1:0]              irq_src,
  output logic                          irq_out
);

  localparam int BSHIFT  = (BUS_W == 32) ? 2 : 1;
  localparam int ACK_IDX = N_OUT_REGS + N_IN_REGS;
  localparam int N_OUTP  = N_OUT_REGS * REG_W;
  localparam int N_INP   = N_IN_REGS * REG_W;
  localparam logic [15:0] CLR_CODE = INV_ACK ? 16'h0000 : 16'hFFFF;

  logic [ADDR_W-1:0] idx;
  assign idx = addr >> BSHIFT;

  logic [N_OUTP-1:0] out_q;
  logic [N_INP-1:0]  in_s1, in_s2;
  logic [N_IRQ-1:0]  src_s1, src_s2, src_s3, rise, pend;
  logic              irq_q;

  wire ack_clr = wr_en && (idx == ADDR_W'(ACK_IDX)) && (wdata[15:0] == CLR_CODE);
  wire out_wr  = wr_en && (idx < ADDR_W'(N_OUT_REGS));

  genvar g;
  generate
    for (g = 0; g < N_OUT_REGS; g++) begin : g_out
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)
          out_q[g*REG_W +: REG_W] <= '0;
        else if (wr_en && idx == ADDR_W'(g))
          out_q[g*REG_W +: REG_W] <= wdata[REG_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_s1  <= '0;
      in_s2  <= '0;
      src_s1 <= '0;
      src_s2 <= '0;
      src_s3 <= '0;
      pend   <= '0;
      irq_q  <= 1'b0;
    end else begin
      in_s1  <= in_pins;
      in_s2  <= in_s1;
      src_s1 <= irq_src;
      src_s2 <= src_s1;
      src_s3 <= src_s2;
      pend   <= (ack_clr ? '0 : pend) | rise;
      irq_q  <= !ack_clr && (|pend);
    end

  assign rise     = src_s2 & ~src_s3;
  assign out_pins = out_q;
  assign irq_out  = irq_q;

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_OUT_REGS; i++)
      if (idx == ADDR_W'(i)) rdata[REG_W-1:0] = out_q[i*REG_W +: REG_W];
    for (int i = 0; i < N_IN_REGS; i++)
      if (idx == ADDR_W'(N_OUT_REGS + i)) rdata[REG_W-1:0] = in_s2[i*REG_W +: REG_W];
    if (idx == ADDR_W'(ACK_IDX)) rdata[N_IRQ-1:0] = pend;
  end

  assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !out_wr |=> $stable(out_pins));
  assert_edge_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((pend & $past(rise)) == $past(rise)));
  assert_edge_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clr && rise == '0) |=> (pend == '0));
  assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_clr |=> !irq_out);
  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_clr && (|pend)) |=> irq_out);
  assert_pend_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_clr |=> ((pend & $past(pend)) == $past(pend)));

endmodule

// File: tb/gpio_irq_expander_bench.sv
module gpio_irq_expander_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [15:0] out_pins;
  logic [15:0] in_pins = '0;
  logic [7:0]  irq_src = '0;
  logic        irq_out;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_expander u_gpio_irq_expander (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .out_pins(out_pins), .in_pins(in_pins),
    .irq_src(irq_src), .irq_out(irq_out));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  initial begin
    logic [15:0] rd;
    logic [15:0] model_out;
    logic [7:0]  model_pend;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk("R10 out", 32'(out_pins), 0);
    chk("R10 irq", 32'(irq_out), 0);
    bus_rd(8'h08, rd); chk("R10 pend", 32'(rd), 0);

    // R2 R3: sweep each output register, neighbour watched
    model_out = '0;
    for (int r = 0; r < 2; r++)
      for (int v = 0; v < 256; v++) begin
        bus_wr(8'(r << 1), 16'(v) | 16'hAB00);
        model_out[r*8 +: 8] = 8'(v);
        chk("R2 R3 pins", 32'(out_pins), 32'(model_out));
        bus_rd(8'(r << 1), rd); chk("R3 readback", 32'(rd), 32'(v));
      end
    // R1 low address bit ignored
    bus_wr(8'h03, 16'h005A); model_out[15:8] = 8'h5A;
    chk("R1 low bit", 32'(out_pins), 32'(model_out));
    // R1 unmapped index
    bus_wr(8'h0A, 16'hFFFF);
    chk("R1 unmapped write", 32'(out_pins), 32'(model_out));
    bus_rd(8'h0A, rd); chk("R1 unmapped read", 32'(rd), 0);

    // R2 R4 input sweep
    for (int r = 0; r < 2; r++)
      for (int v = 0; v < 256; v++) begin
        @(negedge clk); in_pins = 16'(v) << (r*8);
        @(negedge clk);
        bus_rd(8'((2 + r) << 1), rd);
        chk("R2 R4 input", 32'(rd), 32'(v));
      end
    bus_wr(8'h06, 16'h0055);
    bus_rd(8'h06, rd); chk("R4 write ignored", 32'(rd), 32'(in_pins[15:8]));
    chk("R4 write no out effect", 32'(out_pins), 32'(model_out));

    // R5 R6 R9 single sources accumulate
    model_pend = '0;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk); irq_src[j] = 1'b1;
      repeat (4) @(negedge clk);
      model_pend[j] = 1'b1;
      bus_rd(8'h08, rd); chk("R5 R6 pend", 32'(rd), 32'(model_pend));
      chk("R9 irq high", 32'(irq_out), 1);
    end
    // R7 wrong code
    bus_wr(8'h08, 16'h1234);
    bus_rd(8'h08, rd); chk("R7 wrong code", 32'(rd), 32'(model_pend));
    // R7 R9 clear
    bus_wr(8'h08, 16'hFFFF);
    chk("R9 drop", 32'(irq_out), 0);
    repeat (3) @(negedge clk);
    bus_rd(8'h08, rd); chk("R6 level no retrigger", 32'(rd), 0);
    chk("R9 stays low", 32'(irq_out), 0);
    // R6 several at once
    @(negedge clk); irq_src = '0;
    repeat (3) @(negedge clk);
    irq_src = 8'hA5;
    repeat (4) @(negedge clk);
    bus_rd(8'h08, rd); chk("R6 multi", 32'(rd), 32'h00A5);

    // R8 edge in same cycle as clear
    @(negedge clk); irq_src[1] = 1'b1;
    @(negedge clk);
    @(negedge clk); addr = 8'h08; wdata = 16'hFFFF; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; #1;
    chk("R8 edge survives", 32'(rdata), 32'h0002);
    chk("R9 low after clear", 32'(irq_out), 0);
    @(negedge clk); #1;
    chk("R9 rises again", 32'(irq_out), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule